// File: doc/BRIEF.md
# 1-Wire Bit Slot Engine

This block is the bit-level master of a 1-Wire bus. A requester hands it one slot at a time, either a write of a single bit or a read of a single bit. The block pulls the open-drain line low, times the whole slot in whole microseconds with its own one-shot counter, and signals when the slot is over. Slot timing therefore does not depend on software latency. Byte assembly, bus reset and presence detection, and device commands are the requester's job.

Each slot has one counter with two marks. At the first mark the line is released (write) or the line level is taken (read). At the second mark the slot ends and completion is reported. The line is modelled as an output enable for an open-drain driver, where 1 means pull low, together with the raw line level. The line level passes through a synchronizer before the block uses it.

The request side is a valid/ready port. `req_ready_o` is high only while no slot is running. A request is taken on a clock edge where both valid and ready are high. A requester that holds valid high while ready is low waits, and its request is not queued. The response side has no back-pressure. `done_o` is a single-cycle pulse that the requester must catch. `err_o` and `rbit_o` are level outputs and stay stable between the events that change them.

Top module: `onewire_slot_engine`

## Requirements
- R1: After reset and whenever no slot runs, `bus_oe_o` is 0, `req_ready_o` is 1 and `done_o` is 0. Reset also clears `rbit_o` and `err_o` to 0.
- R2: A request is taken only on an edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` stays 0 from the edge after acceptance through the end of the slot. While it is 0, valid, op and bit changes have no effect on the running slot's timing or result.
- R3: Write slot, `req_op_i`=0, `req_bit_i`=1: `bus_oe_o` rises right after the accepting edge and stays high for exactly 1 µs (CLK_PER_US cycles).
- R4: Write slot, `req_op_i`=0, `req_bit_i`=0: `bus_oe_o` stays high for exactly 65 µs after acceptance and is then released for the rest of the slot.
- R5: A write slot lasts 70 µs. `done_o` is high for the one cycle that follows the edge 70·CLK_PER_US cycles after the accepting edge. The low edge and the start of counting coincide.
- R6: Read slot, `req_op_i`=1: `bus_oe_o` is high for exactly 1 µs. The slot counter restarts at the release, and `done_o` pulses 61 µs after the release, which is 62 µs after acceptance.
- R7: In a read slot, `rbit_o` takes the synchronized line level 10 µs after the release. It keeps that value through later write slots until the next read sample.
- R8: `done_o` is a single-cycle pulse, issued only at the slot's terminal count. `req_ready_o` is 1 in the same cycle as `done_o`, so a new slot can be accepted on the next edge.
- R9: If a slot has not ended within WDOG_CYC clock cycles of acceptance, the block returns to idle with `bus_oe_o` at 0, pulses `done_o` and sets `err_o`. With the default parameters this limit is 2 ms.
- R10: `err_o` holds until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_PER_US cycles per microsecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Slot request valid |
| req_ready_o | output | 1 | Block idle, request can be taken |
| req_op_i | input | 1 | 0 = write slot, 1 = read slot |
| req_bit_i | input | 1 | Bit value for a write slot |
| done_o | output | 1 | One-cycle slot completion pulse |
| rbit_o | output | 1 | Last sampled read bit |
| err_o | output | 1 | Slot timed out; cleared by next accepted request |
| bus_oe_o | output | 1 | Open-drain enable, 1 pulls the line low |
| bus_i | input | 1 | Raw line level |

## Verification
A behavioural model counts cycles since acceptance and is compared with every output on every clock. It is driven with a write of 1 and a write of 0, which differ only in the release point, and with reads against a device that leaves the line high and one that holds it low, which differ only in the sampled bit. A run with valid held high across a running slot, with op and bit flipped while the slot runs, separates correct request gating from accidental re-triggering. Back-to-back slots show that ready returns in the done cycle. A second instance with a short watchdog limit checks the timeout path and shows that the next accepted request clears the error.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic {
    OP_WRITE = 1'b0,
    OP_READ  = 1'b1
  } ow_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WR   = 2'd1,
    ST_RLOW = 2'd2,
    ST_RD   = 2'd3
  } ow_state_e;
endpackage

// File: rtl/ow_tick.sv
// Microsecond tick: one pulse every DIV clocks, re-phased by clr.
module ow_tick #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;

  assign tick_o = (pre_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (clr_i)  pre_q <= '0;
    else if (tick_o) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  assert_tick_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST);
endmodule

// File: rtl/ow_slot_cnt.sv
// One-shot up counter in microsecond steps.
module ow_slot_cnt #(
  parameter int MAX_US = 70
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr_i,
  input  logic                        run_i,
  input  logic                        tick_i,
  output logic [$clog2(MAX_US+1)-1:0] cnt_o
);
  localparam int CW = $clog2(MAX_US + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_o <= '0;
    else if (clr_i)           cnt_o <= '0;
    else if (run_i && tick_i) cnt_o <= cnt_o + 1'b1;
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= CW'(MAX_US));
endmodule

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= {STAGES{RST_VAL}};
    else        sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ow_watchdog.sv
module ow_watchdog #(
  parameter int LIMIT = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expire_o
);
  localparam int WW = $clog2(LIMIT);
  logic [WW-1:0] cnt_q;

  assign expire_o = run_i && (cnt_q == WW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_i)     cnt_q <= '0;
    else if (!expire_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/onewire_slot_engine.sv
module onewire_slot_engine
  import ow_pkg::*;
#(
  parameter int CLK_PER_US    = 50,
  parameter int W_SLOT_US     = 70,
  parameter int W_ONE_REL_US  = 1,
  parameter int W_ZERO_REL_US = 65,
  parameter int R_LOW_US      = 1,
  parameter int R_SAMPLE_US   = 10,
  parameter int R_SLOT_US     = 61,
  parameter int WDOG_CYC      = CLK_PER_US * 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid_i,
  output logic req_ready_o,
  input  logic req_op_i,
  input  logic req_bit_i,
  output logic done_o,
  output logic rbit_o,
  output logic err_o,
  output logic bus_oe_o,
  input  logic bus_i
);
  localparam int MAX_US = (W_SLOT_US > R_SLOT_US) ? W_SLOT_US : R_SLOT_US;
  localparam int CW     = $clog2(MAX_US + 1);
  localparam logic [CW-1:0] W_END    = CW'(W_SLOT_US - 1);
  localparam logic [CW-1:0] W_REL1   = CW'(W_ONE_REL_US - 1);
  localparam logic [CW-1:0] W_REL0   = CW'(W_ZERO_REL_US - 1);
  localparam logic [CW-1:0] R_REL    = CW'(R_LOW_US - 1);
  localparam logic [CW-1:0] R_SMP    = CW'(R_SAMPLE_US - 1);
  localparam logic [CW-1:0] R_END    = CW'(R_SLOT_US - 1);

  ow_state_e     st_q;
  logic          wbit_q;
  logic          tick, bus_s, wd_exp;
  logic [CW-1:0] cnt;
  logic          accept, rel_edge, w_rel, w_end, r_smp, r_end;
  logic [CW-1:0] w_rel_pt;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;
  assign w_rel_pt    = wbit_q ? W_REL1 : W_REL0;
  assign rel_edge    = (st_q == ST_RLOW) && tick && (cnt == R_REL);
  assign w_rel       = (st_q == ST_WR) && tick && (cnt == w_rel_pt);
  assign w_end       = (st_q == ST_WR) && tick && (cnt == W_END);
  assign r_smp       = (st_q == ST_RD) && tick && (cnt == R_SMP);
  assign r_end       = (st_q == ST_RD) && tick && (cnt == R_END);

  ow_tick #(.DIV(CLK_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr_i(accept || rel_edge), .tick_o(tick));

  ow_slot_cnt #(.MAX_US(MAX_US)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(accept || rel_edge || req_ready_o),
    .run_i(!req_ready_o), .tick_i(tick), .cnt_o(cnt));

  ow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(bus_i), .q_o(bus_s));

  ow_watchdog #(.LIMIT(WDOG_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_n), .run_i(!req_ready_o), .expire_o(wd_exp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      wbit_q   <= 1'b0;
      bus_oe_o <= 1'b0;
      done_o   <= 1'b0;
      rbit_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (wd_exp) begin
        st_q     <= ST_IDLE;
        bus_oe_o <= 1'b0;
        done_o   <= 1'b1;
        err_o    <= 1'b1;
      end else begin
        unique case (st_q)
          ST_IDLE: if (accept) begin
            err_o    <= 1'b0;
            bus_oe_o <= 1'b1;
            wbit_q   <= req_bit_i;
            st_q     <= (req_op_i == OP_READ) ? ST_RLOW : ST_WR;
          end
          ST_WR: begin
            if (w_rel) bus_oe_o <= 1'b0;
            if (w_end) begin
              bus_oe_o <= 1'b0;
              done_o   <= 1'b1;
              st_q     <= ST_IDLE;
            end
          end
          ST_RLOW: if (rel_edge) begin
            bus_oe_o <= 1'b0;
            st_q     <= ST_RD;
          end
          ST_RD: begin
            if (r_smp) rbit_o <= bus_s;
            if (r_end) begin
              done_o <= 1'b1;
              st_q   <= ST_IDLE;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !bus_oe_o);
  assert_low_only_on_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe_o) |-> $past(req_valid_i && req_ready_o));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> req_ready_o);
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> done_o);
  assert_rbit_only_in_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rbit_o) |-> $past(st_q == ST_RD));
endmodule

// File: tb/onewire_slot_engine_test.sv
`timescale 1ns/1ps
module onewire_slot_engine_test;
  localparam int DIV = 50;
  localparam int WD  = 1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_op = 1'b0, req_bit = 1'b0;
  logic ready, done, rbit, err, oe;
  logic slave_lvl = 1'b1;
  wire  bus_line = ~oe & slave_lvl;

  onewire_slot_engine #(.CLK_PER_US(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .req_ready_o(ready),
    .req_op_i(req_op), .req_bit_i(req_bit), .done_o(done), .rbit_o(rbit),
    .err_o(err), .bus_oe_o(oe), .bus_i(bus_line));

  logic wd_valid = 1'b0, wd_op = 1'b0;
  logic wd_ready, wd_done, wd_rbit, wd_err, wd_oe;
  onewire_slot_engine #(.CLK_PER_US(DIV), .WDOG_CYC(WD)) uut_wd (
    .clk(clk), .rst_n(rst_n), .req_valid_i(wd_valid), .req_ready_o(wd_ready),
    .req_op_i(wd_op), .req_bit_i(1'b1), .done_o(wd_done), .rbit_o(wd_rbit),
    .err_o(wd_err), .bus_oe_o(wd_oe), .bus_i(1'b1));

  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit m_busy, m_op, m_bit, m_done, m_oe, m_rbit;
  int m_cyc;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cyc = 0; m_done = 0; m_oe = 0; m_rbit = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cyc++;
        if (!m_op) m_oe = (m_cyc < (m_bit ? 1 : 65) * DIV);
        else       m_oe = (m_cyc < DIV);
        if (m_op && m_cyc == 11 * DIV) m_rbit = slave_lvl;
        if (m_cyc == (m_op ? 62 : 70) * DIV) begin
          m_busy = 0; m_done = 1; m_oe = 0;
        end
      end else if (req_valid) begin
        m_busy = 1; m_cyc = 0; m_oe = 1; m_op = req_op; m_bit = req_bit;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ready == !m_busy, "R2 ready", ready, !m_busy);
      chk(oe == m_oe, !m_busy ? "R1 oe idle" : m_op ? "R6 oe" : m_bit ? "R3 oe" : "R4 oe", oe, m_oe);
      chk(done == m_done, m_op ? "R6 done" : "R5 done", done, m_done);
      chk(rbit == m_rbit, "R7 rbit", rbit, m_rbit);
      chk(err == 1'b0, "R9 err", err, 0);
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  int cyc_total = 0;
  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  // Run one slot; hold valid for extra cycles with op/bit flipped.
  task automatic slot(input bit op, input bit b, input int hold,
                      output int len, output int oe_cyc, output int dones);
    req_valid = 1; req_op = op; req_bit = b;
    len = 0; oe_cyc = 0; dones = 0;
    for (int i = 0; i < 10000; i++) begin
      @(posedge clk); len++;
      @(negedge clk);
      if (len == 1) begin req_op = ~op; req_bit = ~b; end
      if (len > hold) req_valid = 0;
      if (oe) oe_cyc++;
      if (done) begin dones++; break; end
    end
    req_valid = 0;
    @(posedge clk); @(negedge clk);
    if (done) dones++;
  endtask

  int len, ocyc, dn;
  initial begin
    repeat (3) @(negedge clk);
    chk(oe == 0, "R1 reset oe", oe, 0);
    chk(ready == 1, "R1 reset ready", ready, 1);
    chk(done == 0 && err == 0 && rbit == 0, "R1 reset outs", {done, err, rbit}, 0);
    rst_n = 1;
    @(negedge clk);

    slot(0, 1, 0, len, ocyc, dn);
    chk(ocyc == DIV, "R3 low width", ocyc, DIV);
    chk(len == 70 * DIV + 1, "R5 write length", len, 70 * DIV + 1);
    chk(dn == 1, "R8 one done", dn, 1);

    slot(0, 0, 0, len, ocyc, dn);
    chk(ocyc == 65 * DIV, "R4 low width", ocyc, 65 * DIV);
    chk(len == 70 * DIV + 1, "R5 write0 length", len, 70 * DIV + 1);

    slave_lvl = 1;
    slot(1, 0, 0, len, ocyc, dn);
    chk(ocyc == DIV, "R6 read low", ocyc, DIV);
    chk(len == 62 * DIV + 1, "R6 read length", len, 62 * DIV + 1);
    chk(rbit == 1, "R7 read one", rbit, 1);

    slave_lvl = 0;
    slot(1, 1, 0, len, ocyc, dn);
    chk(rbit == 0, "R7 read zero", rbit, 0);
    slave_lvl = 1;
    slot(0, 1, 0, len, ocyc, dn);
    chk(rbit == 0, "R7 hold over write", rbit, 0);

    // R2: valid held through busy time with flipped op/bit
    slot(0, 1, 2000, len, ocyc, dn);
    chk(len == 70 * DIV + 1, "R2 busy ignore length", len, 70 * DIV + 1);
    chk(ocyc == DIV, "R2 busy ignore width", ocyc, DIV);
    chk(dn == 1, "R2 single completion", dn, 1);

    // R8 back-to-back: request waiting as done arrives
    req_valid = 1; req_op = 0; req_bit = 1;
    wait (done); @(posedge clk); @(negedge clk);
    chk(oe == 1 && ready == 0, "R8 back-to-back accept", {oe, ready}, 2);
    req_valid = 0;
    wait (done); @(negedge clk);

    // R9/R10 on short-watchdog instance
    wd_valid = 1; wd_op = 0;
    len = 0;
    for (int i = 0; i < 5000; i++) begin
      @(posedge clk); len++;
      @(negedge clk);
      wd_valid = 0;
      if (wd_done) break;
    end
    chk(len == WD + 1, "R9 timeout cycle", len, WD + 1);
    chk(wd_err == 1, "R9 err set", wd_err, 1);
    chk(wd_oe == 0 && wd_ready == 1, "R9 released idle", {wd_oe, wd_ready}, 1);
    repeat (5) @(negedge clk);
    chk(wd_err == 1, "R10 err held", wd_err, 1);
    wd_valid = 1; wd_op = 1;
    @(posedge clk); @(negedge clk);
    wd_valid = 0;
    chk(wd_err == 0, "R10 err cleared", wd_err, 0);
    wait (wd_done); @(negedge clk);
    chk(wd_err == 1, "R9 read timeout", wd_err, 1);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule